// File: doc/BRIEF.md
# Dual-Channel Quaternary Pulse-Position Encoder

This block turns two streams of two-bit words into two streams of quaternary pulse-position symbols. Each symbol has four time slots. When the channel is enabled, the value of the word picks the one slot that carries a pulse. The block runs on the slot clock, which is twice the input bit rate, so a new word pair arrives once every four clock cycles. A strobe marks each new word pair. At the clock edge that accepts a pair, the block captures both words, the cross-channel mode and the two channel blanking inputs together.

In cross mode the two channels swap their least significant bits before encoding, and each channel keeps its own most significant bit. This lets a channel that is easy to measure share errors with one that is hard to measure. A blanking input makes its channel send a symbol with no pulse in any slot, so a channel that is off on purpose can be told apart from one that has failed. Both channels serialize in lock-step. Slot 0 goes out first.

Top module: `qppm_dual_enc`

## Requirements
- R1: When a channel is not blanked, each symbol holds exactly one pulse. Word value 00 puts the pulse in slot 0, 01 in slot 1, 10 in slot 2 and 11 in slot 3.
- R2: A word pair is captured at the rising edge where `pair_vld` is high and the pair is accepted. Slot 0 of that symbol appears on the outputs during the cycle right after that edge, and slots 1, 2 and 3 follow on the next three cycles.
- R3: With `xlv_mode` = 0, channel A encodes `cha_bits` and channel B encodes `chb_bits` unchanged.
- R4: With `xlv_mode` = 1, channel A encodes {`cha_bits[1]`, `chb_bits[0]`} and channel B encodes {`chb_bits[1]`, `cha_bits[0]`}.
- R5: A channel whose blanking input (`cha_off` or `chb_off`) is high at capture outputs 0 in all four slots of that symbol. The other channel is not affected.
- R6: `xlv_mode`, the blanking inputs and the bit inputs are sampled only at capture. Changing them while a symbol is being sent does not alter that symbol.
- R7: If `pair_vld` is high while slot 0, 1 or 2 of a symbol is on the outputs, it is ignored. If it is high while slot 3 is on the outputs, the pair is accepted, so symbols can run back to back with no gap.
- R8: After reset, and in any cycle where no symbol is being sent, both outputs are 0.
- R9: Both channels send their symbols on the same slot boundaries. Equal encoded words give identical output streams in the same cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slot clock, twice the input bit rate |
| rst | input | 1 | Synchronous active-high reset |
| pair_vld | input | 1 | Strobe that offers a new word pair |
| cha_bits | input | 2 | Channel A word |
| chb_bits | input | 2 | Channel B word |
| xlv_mode | input | 1 | 1 = swap the least significant bits between the channels |
| cha_off | input | 1 | Blank channel A for the captured symbol |
| chb_off | input | 1 | Blank channel B for the captured symbol |
| cha_slot | output | 1 | Channel A serial slot stream |
| chb_slot | output | 1 | Channel B serial slot stream |

## Verification
Some properties are checked on every cycle. No symbol register ever holds more than one pulse. Outputs stay quiet whenever no symbol is in flight. A blanked capture never produces a pulse in slot 0. A strobe in the middle of a symbol never restarts the slot count. Other behaviour can only be shown by the bench's scenarios: the full mapping from word value to slot position under both modes, the bit swap across the channels, back-to-back symbol timing, and the fact that changes to the inputs during a symbol are ignored. Each of these depends on a complete four-slot stream compared with a value worked out from the requirements.

// File: rtl/qppm_pkg.sv
package qppm_pkg;

    localparam int BITS_PER_SYM = 2;
    localparam int SLOTS        = 1 << BITS_PER_SYM;
    localparam int NUM_CH       = 2;
    localparam int CNT_W        = $clog2(SLOTS);

    typedef logic [BITS_PER_SYM-1:0] word_t;
    typedef logic [SLOTS-1:0]        slot_vec_t;
    typedef logic [CNT_W-1:0]        slot_idx_t;

    typedef enum logic {
        MODE_DIRECT = 1'b0,
        MODE_CROSS  = 1'b1
    } lane_mode_e;

    typedef struct packed {
        logic  blank;
        word_t code;
    } lane_req_t;

    // Bit i of the result is the level of slot i.
    function automatic slot_vec_t code_to_slots(lane_req_t req);
        slot_vec_t v;
        v = '0;
        if (!req.blank) v[req.code] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/qppm_frame_ctl.sv
module qppm_frame_ctl
    import qppm_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      pair_vld,
    output logic      accept,
    output logic      busy,
    output slot_idx_t slot_idx
);

    localparam slot_idx_t LAST_SLOT = slot_idx_t'(SLOTS - 1);

    logic      busy_q;
    slot_idx_t cnt_q;

    assign accept   = pair_vld && (!busy_q || cnt_q == LAST_SLOT);
    assign busy     = busy_q;
    assign slot_idx = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (accept) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
        end else if (busy_q) begin
            if (cnt_q == LAST_SLOT) begin
                busy_q <= 1'b0;
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R7: a strobe inside a symbol never restarts the slot count
    a_r7_midsym_ignored: assert property (@(posedge clk) disable iff (rst)
        (busy_q && cnt_q != LAST_SLOT) |=>
            (busy_q && cnt_q == slot_idx_t'($past(cnt_q) + 1'b1)));

    // R2: every accepted pair starts a symbol at slot 0
    a_r2_start_slot0: assert property (@(posedge clk) disable iff (rst)
        accept |=> (busy_q && cnt_q == '0));

endmodule

// File: rtl/qppm_lane_mux.sv
module qppm_lane_mux
    import qppm_pkg::*;
(
    input  lane_mode_e                    mode,
    input  logic [NUM_CH-1:0][BITS_PER_SYM-1:0] word_in,
    output logic [NUM_CH-1:0][BITS_PER_SYM-1:0] word_out
);

    // In cross mode each lane takes its LSB from the neighbouring lane.
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_lane
        localparam int PEER = (ch + 1) % NUM_CH;
        always_comb begin
            word_out[ch] = word_in[ch];
            if (mode == MODE_CROSS) word_out[ch][0] = word_in[PEER][0];
        end
    end

endmodule

// File: rtl/qppm_sym_ser.sv
module qppm_sym_ser
    import qppm_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  lane_req_t req,
    output logic      slot_o
);

    slot_vec_t shreg_q;

    always_ff @(posedge clk) begin
        if (rst)       shreg_q <= '0;
        else if (load) shreg_q <= code_to_slots(req);
        else           shreg_q <= shreg_q >> 1;
    end

    assign slot_o = shreg_q[0];

    // R1: at most one pulse is ever pending in a symbol
    a_r1_single_pulse: assert property (@(posedge clk) disable iff (rst)
        $onehot0(shreg_q));

    // R1: code zero puts its pulse in the first slot
    a_r1_code0_first: assert property (@(posedge clk) disable iff (rst)
        (load && !req.blank && req.code == '0) |=> slot_o);

    // R5: a blanked capture leaves slot 0 empty
    a_r5_blank_slot0: assert property (@(posedge clk) disable iff (rst)
        (load && req.blank) |=> !slot_o);

endmodule

// File: rtl/qppm_dual_enc.sv
module qppm_dual_enc
    import qppm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       pair_vld,
    input  logic [1:0] cha_bits,
    input  logic [1:0] chb_bits,
    input  logic       xlv_mode,
    input  logic       cha_off,
    input  logic       chb_off,
    output logic       cha_slot,
    output logic       chb_slot
);

    logic      accept;
    logic      busy;
    slot_idx_t slot_idx;

    logic [NUM_CH-1:0][BITS_PER_SYM-1:0] raw_words;
    logic [NUM_CH-1:0][BITS_PER_SYM-1:0] lane_words;
    logic [NUM_CH-1:0]                   blank_v;
    logic [NUM_CH-1:0]                   slot_v;

    assign raw_words = {chb_bits, cha_bits};
    assign blank_v   = {chb_off, cha_off};

    qppm_frame_ctl u_ctl (
        .clk      (clk),
        .rst      (rst),
        .pair_vld (pair_vld),
        .accept   (accept),
        .busy     (busy),
        .slot_idx (slot_idx)
    );

    qppm_lane_mux u_mux (
        .mode     (lane_mode_e'(xlv_mode)),
        .word_in  (raw_words),
        .word_out (lane_words)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        lane_req_t req;
        assign req.blank = blank_v[ch];
        assign req.code  = lane_words[ch];

        qppm_sym_ser u_ser (
            .clk    (clk),
            .rst    (rst),
            .load   (accept),
            .req    (req),
            .slot_o (slot_v[ch])
        );
    end

    assign cha_slot = slot_v[0];
    assign chb_slot = slot_v[1];

    // R8: no pulse leaves the block while no symbol is in flight
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!cha_slot && !chb_slot));

    // R9: a pulse in the last slot ends the symbol on both lanes
    a_r9_aligned_end: assert property (@(posedge clk) disable iff (rst)
        (busy && slot_idx == slot_idx_t'(SLOTS - 1) && !accept) |=>
            (!cha_slot && !chb_slot));

endmodule

// File: tb/qppm_dual_enc_tb.sv
module qppm_dual_enc_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pair_vld = 1'b0;
    logic [1:0] cha_bits = '0;
    logic [1:0] chb_bits = '0;
    logic       xlv_mode = 1'b0;
    logic       cha_off = 1'b0;
    logic       chb_off = 1'b0;
    logic       cha_slot;
    logic       chb_slot;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    qppm_dual_enc u_dut (
        .clk      (clk),
        .rst      (rst),
        .pair_vld (pair_vld),
        .cha_bits (cha_bits),
        .chb_bits (chb_bits),
        .xlv_mode (xlv_mode),
        .cha_off  (cha_off),
        .chb_off  (chb_off),
        .cha_slot (cha_slot),
        .chb_slot (chb_slot)
    );

    typedef struct packed {
        logic       m;
        logic       oa;
        logic       ob;
        logic [1:0] a;
        logic [1:0] b;
        logic [3:0] ea;   // bit i = expected level in slot i
        logic [3:0] eb;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 1'b0, 2'b00, 2'b11, 4'b0001, 4'b1000},
        '{1'b0, 1'b0, 1'b0, 2'b01, 2'b10, 4'b0010, 4'b0100},
        '{1'b0, 1'b0, 1'b0, 2'b10, 2'b01, 4'b0100, 4'b0010},
        '{1'b0, 1'b0, 1'b0, 2'b11, 2'b00, 4'b1000, 4'b0001},
        '{1'b1, 1'b0, 1'b0, 2'b01, 2'b10, 4'b0001, 4'b1000},
        '{1'b1, 1'b0, 1'b0, 2'b10, 2'b01, 4'b1000, 4'b0001},
        '{1'b1, 1'b0, 1'b0, 2'b11, 2'b11, 4'b1000, 4'b1000},
        '{1'b0, 1'b1, 1'b0, 2'b10, 2'b10, 4'b0000, 4'b0100},
        '{1'b1, 1'b0, 1'b1, 2'b00, 2'b01, 4'b0010, 4'b0000},
        '{1'b0, 1'b1, 1'b1, 2'b01, 2'b01, 4'b0000, 4'b0000}
    };

    task automatic check(input bit ok, input string tag,
                         input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // Called at a negedge; returns at the negedge showing slot 3.
    task automatic run_sym(input vec_t v, input bit disturb, input string tag);
        logic [3:0] ga;
        logic [3:0] gb;
        xlv_mode = v.m; cha_off = v.oa; chb_off = v.ob;
        cha_bits = v.a; chb_bits = v.b; pair_vld = 1'b1;
        for (int s = 0; s < 4; s++) begin
            @(negedge clk);
            ga[s] = cha_slot;
            gb[s] = chb_slot;
            if (s == 0) begin
                pair_vld = 1'b0;
                if (disturb) begin
                    xlv_mode = ~v.m; cha_off = ~v.oa; chb_off = ~v.ob;
                    cha_bits = ~v.a; chb_bits = ~v.b; pair_vld = 1'b1;
                end
            end else if (s == 1) begin
                pair_vld = 1'b0;
            end
        end
        check(ga == v.ea, {tag, " chA"}, ga, v.ea);
        check(gb == v.eb, {tag, " chB"}, gb, v.eb);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R8: quiet after reset with no strobe
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(!cha_slot && !chb_slot, "R8 idle after reset",
                  {2'b0, chb_slot, cha_slot}, 4'b0000);
        end

        // R1 R2 R3 R4 R5 R9: table walked back to back (R7 last-slot accept)
        for (int i = 0; i < NV; i++) begin
            string tag;
            case (i)
                0, 1, 2, 3: tag = $sformatf("R1_R2_R3_R7 vec%0d", i);
                4, 5:       tag = $sformatf("R4 vec%0d", i);
                6:          tag = $sformatf("R4_R9 vec%0d", i);
                default:    tag = $sformatf("R5 vec%0d", i);
            endcase
            run_sym(VECS[i], 1'b0, tag);
        end

        // R8: the symbol ends and the outputs go quiet
        @(negedge clk);
        check(!cha_slot && !chb_slot, "R8 idle after last symbol",
              {2'b0, chb_slot, cha_slot}, 4'b0000);
        @(negedge clk);
        check(!cha_slot && !chb_slot, "R8 idle gap",
              {2'b0, chb_slot, cha_slot}, 4'b0000);

        // R6 and R7: inputs flipped and a strobe during slot 0 are ignored
        run_sym('{1'b0, 1'b0, 1'b0, 2'b10, 2'b11, 4'b0100, 4'b1000}, 1'b1,
                "R6_R7 mid-symbol change");
        run_sym('{1'b1, 1'b0, 1'b1, 2'b01, 2'b00, 4'b0001, 4'b0000}, 1'b1,
                "R6_R7 mid-symbol change cross");

        // R9: equal words on both lanes, checked slot by slot
        xlv_mode = 1'b0; cha_off = 1'b0; chb_off = 1'b0;
        cha_bits = 2'b01; chb_bits = 2'b01; pair_vld = 1'b1;
        for (int s = 0; s < 4; s++) begin
            @(negedge clk);
            pair_vld = 1'b0;
            check(cha_slot == chb_slot && cha_slot == (s == 1), "R9 lock-step slot",
                  {2'b0, chb_slot, cha_slot}, (s == 1) ? 4'b0011 : 4'b0000);
        end

        @(negedge clk);
        check(!cha_slot && !chb_slot, "R8 idle at end",
              {2'b0, chb_slot, cha_slot}, 4'b0000);
        finish_run();
    end

endmodule